// File: doc/BRIEF.md
# Concurrent Snapshot Scan-Out Register

This block lets a tester look inside a running piecewise-affine evaluator without stopping it. When the mode input selects test operation and a capture request arrives, it takes one atomic picture of three internal buses: the address presented to the tree memory, the word read from the tree memory, and the word read from the parameter memory. All of these bits land in one frame register on the same clock edge.

The frame is then streamed out on a single serial pin, one bit per clock, most significant bit first. A busy flag frames the stream. While the stream runs, the evaluator and the buses keep changing freely, and none of that reaches the shifted bits. When no stream is running, the serial pin rests low. The field widths, the mode code that enables the path and the shift direction are parameters, so the same block fits other evaluator sizes.

Top module: `snap_scan_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy is 0 and ser_out is 0.
- R2: The frame is 86 bits wide. Bits 85..72 hold tree_addr[13:0], bits 71..60 hold tree_data[11:0], and bits 59..0 hold param_data[59:0]. The stream sends bit 85 first and bit 0 last.
- R3: A request (cap_req = 1 while mode = 2'b11 and busy = 0) sampled at a clock edge loads all 86 bits at that edge. In the following cycle busy is 1 and ser_out shows frame bit 85.
- R4: After an accepted request, busy stays 1 for exactly 86 consecutive cycles. In the k-th of those cycles (k = 0..85), ser_out carries frame bit 85-k.
- R5: Changes on tree_addr, tree_data or param_data after the capture edge do not alter the stream.
- R6: A request sampled while busy is 1 is ignored. This includes the last busy cycle. The running stream keeps its content and length.
- R7: A request sampled while mode is not 2'b11 is ignored. busy stays 0 and ser_out stays 0.
- R8: Whenever busy is 0, ser_out is 0.
- R9: A mode change away from 2'b11 during a stream does not cut the stream short or alter it.
- R10: A request sampled in the first cycle after busy falls is accepted, so back-to-back frames are separated by one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Operating mode; 2'b11 enables capture |
| cap_req | input | 1 | Capture request, sampled at each clock edge |
| tree_addr | input | 14 | Current tree memory address |
| tree_data | input | 12 | Current tree memory read word |
| param_data | input | 60 | Current parameter memory read word |
| ser_out | output | 1 | Serial snapshot bit, MSB first, 0 when idle |
| busy | output | 1 | High while a snapshot is being shifted |

## Verification
The bench goes after the field order and bit order. It uses frames whose fields have distinct and lopsided bit patterns, so a design that swapped fields or shifted LSB first would send a visibly different stream. It changes the buses and mode in the middle of a stream and also fires extra requests there. A design that reloaded while busy, or that followed the live buses, would corrupt the tail of the stream or stretch busy past 86 cycles. It also requests in the first cycle after busy falls and with the wrong mode code. An off-by-one in the length counter would either drop that back-to-back frame or make busy last 85 or 87 cycles. A broken mode gate would start a stream when it must not.

// File: rtl/snap_pkg.sv
package snap_pkg;
   localparam int unsigned DEF_ADDR_W  = 14;
   localparam int unsigned DEF_TDATA_W = 12;
   localparam int unsigned DEF_PDATA_W = 60;
   localparam int unsigned DEF_MODE_W  = 2;

   function automatic int unsigned frame_width(input int unsigned aw,
                                               input int unsigned tw,
                                               input int unsigned pw);
      return aw + tw + pw;
   endfunction

   function automatic int unsigned count_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/snap_frame.sv
module snap_frame #(
   parameter int unsigned ADDR_W  = snap_pkg::DEF_ADDR_W,
   parameter int unsigned TDATA_W = snap_pkg::DEF_TDATA_W,
   parameter int unsigned PDATA_W = snap_pkg::DEF_PDATA_W,
   localparam int unsigned FRAME_W = snap_pkg::frame_width(ADDR_W, TDATA_W, PDATA_W)
) (
   input  logic [ADDR_W-1:0]  tree_addr,
   input  logic [TDATA_W-1:0] tree_data,
   input  logic [PDATA_W-1:0] param_data,
   output logic [FRAME_W-1:0] frame
);
   localparam int unsigned P_LSB = 0;
   localparam int unsigned T_LSB = PDATA_W;
   localparam int unsigned A_LSB = PDATA_W + TDATA_W;

   for (genvar gi = 0; gi < PDATA_W; gi++) begin : g_pfield
      assign frame[P_LSB + gi] = param_data[gi];
   end
   for (genvar gi = 0; gi < TDATA_W; gi++) begin : g_tfield
      assign frame[T_LSB + gi] = tree_data[gi];
   end
   for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_afield
      assign frame[A_LSB + gi] = tree_addr[gi];
   end
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl #(
   parameter int unsigned MODE_W  = snap_pkg::DEF_MODE_W,
   parameter logic [MODE_W-1:0] TEST_CODE = '1,
   parameter int unsigned FRAME_W = 86,
   localparam int unsigned CNT_W = snap_pkg::count_width(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              cap_req,
   output logic              load,
   output logic              shifting
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

   logic             busy_q;
   logic [CNT_W-1:0] left_q;

   assign load     = (mode == TEST_CODE) && cap_req && !busy_q;
   assign shifting = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         left_q <= LAST_IDX;
      end else if (busy_q) begin
         if (left_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            left_q <= left_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/snap_shreg.sv
module snap_shreg #(
   parameter int unsigned FRAME_W = 86,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               advance,
   input  logic [FRAME_W-1:0] frame,
   output logic               head
);
   logic [FRAME_W-1:0] sh_q;

   if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       sh_q <= '0;
         else if (load)    sh_q <= frame;
         else if (advance) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      end
      assign head = sh_q[FRAME_W-1];
   end else begin : g_lsb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       sh_q <= '0;
         else if (load)    sh_q <= frame;
         else if (advance) sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
      end
      assign head = sh_q[0];
   end
endmodule

// File: rtl/snap_scan_top.sv
module snap_scan_top #(
   parameter int unsigned ADDR_W  = snap_pkg::DEF_ADDR_W,
   parameter int unsigned TDATA_W = snap_pkg::DEF_TDATA_W,
   parameter int unsigned PDATA_W = snap_pkg::DEF_PDATA_W,
   parameter int unsigned MODE_W  = snap_pkg::DEF_MODE_W,
   parameter logic [MODE_W-1:0] TEST_CODE = '1,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MODE_W-1:0]  mode,
   input  logic               cap_req,
   input  logic [ADDR_W-1:0]  tree_addr,
   input  logic [TDATA_W-1:0] tree_data,
   input  logic [PDATA_W-1:0] param_data,
   output logic               ser_out,
   output logic               busy
);
   localparam int unsigned FRAME_W = snap_pkg::frame_width(ADDR_W, TDATA_W, PDATA_W);

   if (ADDR_W < 1 || TDATA_W < 1 || PDATA_W < 1) begin : g_bad_width
      $error("snap_scan_top: every field needs at least one bit");
   end
   if (FRAME_W < 2) begin : g_bad_frame
      $error("snap_scan_top: frame must be at least two bits");
   end

   logic [FRAME_W-1:0] frame;
   logic               load;
   logic               head;

   snap_frame #(.ADDR_W(ADDR_W), .TDATA_W(TDATA_W), .PDATA_W(PDATA_W)) u_frame (
      .tree_addr (tree_addr),
      .tree_data (tree_data),
      .param_data(param_data),
      .frame     (frame)
   );

   snap_ctrl #(.MODE_W(MODE_W), .TEST_CODE(TEST_CODE), .FRAME_W(FRAME_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .cap_req (cap_req),
      .load    (load),
      .shifting(busy)
   );

   snap_shreg #(.FRAME_W(FRAME_W), .MSB_FIRST(MSB_FIRST)) u_shreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .advance(busy),
      .frame  (frame),
      .head   (head)
   );

   assign ser_out = busy & head;
endmodule

// File: rtl/snap_scan_chk.sv
module snap_scan_chk #(
   parameter int unsigned ADDR_W  = snap_pkg::DEF_ADDR_W,
   parameter int unsigned TDATA_W = snap_pkg::DEF_TDATA_W,
   parameter int unsigned PDATA_W = snap_pkg::DEF_PDATA_W,
   parameter int unsigned MODE_W  = snap_pkg::DEF_MODE_W,
   parameter logic [MODE_W-1:0] TEST_CODE = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [MODE_W-1:0]  mode,
   input logic               cap_req,
   input logic [ADDR_W-1:0]  tree_addr,
   input logic [TDATA_W-1:0] tree_data,
   input logic [PDATA_W-1:0] param_data,
   input logic               ser_out,
   input logic               busy
);
   localparam int unsigned FRAME_W = snap_pkg::frame_width(ADDR_W, TDATA_W, PDATA_W);
   localparam int unsigned CW = snap_pkg::count_width(FRAME_W) + 1;

   logic [CW-1:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   logic unused_ok;
   assign unused_ok = ^{tree_data, param_data};

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_out); // R8
   AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(mode) == TEST_CODE && $past(cap_req))); // R7
   AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TEST_CODE && cap_req && !busy) |=> (busy && ser_out == $past(tree_addr[ADDR_W-1]))); // R3
   AST_STREAM_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && run_len == CW'(FRAME_W - 1)) |=> !busy); // R4
   AST_STREAM_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(run_len) == CW'(FRAME_W - 1))); // R6
   AST_WRONG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != TEST_CODE && !busy) |=> !busy); // R7
endmodule

bind snap_scan_top snap_scan_chk #(
   .ADDR_W(ADDR_W), .TDATA_W(TDATA_W), .PDATA_W(PDATA_W),
   .MODE_W(MODE_W), .TEST_CODE(TEST_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .cap_req(cap_req),
   .tree_addr(tree_addr), .tree_data(tree_data), .param_data(param_data),
   .ser_out(ser_out), .busy(busy)
);

// File: tb/tb_snap_scan_top.sv
module tb_snap_scan_top;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 86;
   localparam int NVEC = 6;

   // stimulus: {tree_addr, tree_data, param_data}; expected stream is the same frame, bit 85 first
   localparam logic [FW-1:0] VEC [NVEC] = '{
      {14'h2001, 12'h801, 60'h800000000000001},
      {14'h3FFF, 12'h000, 60'hFFFFFFFFFFFFFFF},
      {14'h0000, 12'hFFF, 60'h000000000000000},
      {14'h1A5C, 12'h3C7, 60'h123456789ABCDEF},
      {14'h0001, 12'h800, 60'h0F0F0F0F0F0F0F0},
      {14'h2AAA, 12'h555, 60'hAAAAAAAAAAAAAAA}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        cap_req = 1'b0;
   logic [13:0] tree_addr = '0;
   logic [11:0] tree_data = '0;
   logic [59:0] param_data = '0;
   logic        ser_out;
   logic        busy;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   snap_scan_top dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cap_req(cap_req),
      .tree_addr(tree_addr), .tree_data(tree_data), .param_data(param_data),
      .ser_out(ser_out), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                        input logic [FW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // disturb: 0 none, 1 change buses + extra requests + mode change mid-stream
   task automatic run_frame(input logic [FW-1:0] f, input int disturb, input string req);
      logic [FW-1:0] got = '0;
      int blen = 0;
      mode = 2'b11;
      {tree_addr, tree_data, param_data} = f;
      cap_req = 1'b1;
      @(negedge clk);
      cap_req = 1'b0;
      while (busy && blen < 200) begin
         got = {got[FW-2:0], ser_out};
         blen++;
         if (disturb == 1) begin
            {tree_addr, tree_data, param_data} = ~f ^ FW'(blen * 7919);
            cap_req = (blen % 9 == 0) || (blen == FW);
            mode = (blen > 30 && blen < 50) ? 2'b01 : 2'b11;
         end
         @(negedge clk);
      end
      cap_req = 1'b0;
      check(got == f, {req, " stream"}, got, f);
      check(blen == FW, {req, " busy length"}, FW'(blen), FW'(FW));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && ser_out == 1'b0, "R1 in reset", FW'({busy, ser_out}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && ser_out == 1'b0, "R1 after release", FW'({busy, ser_out}), '0);

      // R2 R3 R4: table walk
      for (int i = 0; i < NVEC; i++) begin
         run_frame(VEC[i], 0, "R2 R4 table");
         check(ser_out == 1'b0, "R8 idle after stream", FW'(ser_out), '0);
         @(negedge clk);
      end

      // R3: first bit visible in the cycle after capture
      mode = 2'b11; {tree_addr, tree_data, param_data} = VEC[0]; cap_req = 1'b1;
      @(negedge clk);
      cap_req = 1'b0;
      check(busy == 1'b1 && ser_out == 1'b1, "R3 first bit", FW'({busy, ser_out}), FW'(2'b11));
      while (busy) @(negedge clk);
      @(negedge clk);

      // R7: wrong mode codes ignored
      for (int m = 0; m < 3; m++) begin
         mode = 2'(m); {tree_addr, tree_data, param_data} = VEC[1]; cap_req = 1'b1;
         @(negedge clk);
         @(negedge clk);
         cap_req = 1'b0;
         check(busy == 1'b0 && ser_out == 1'b0, "R7 wrong mode", FW'({busy, ser_out}), '0);
      end

      // R5 R6 R9: disturbances mid-stream, including a request in the last busy cycle
      run_frame(VEC[3], 1, "R5 R6 R9 disturbed");
      check(busy == 1'b0 && ser_out == 1'b0, "R8 R6 idle after disturbed", FW'({busy, ser_out}), '0);

      // R10: back-to-back frames with one idle cycle between
      run_frame(VEC[4], 0, "R10 first");
      run_frame(VEC[5], 0, "R10 second");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule